// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block turns 31-bit payloads, handed over on a 16-bit parallel bus, into a bipolar return-to-zero bit stream of 32-bit words. A host writes each payload as two half-words, each with its own strobe. The lower half goes first and the upper half second. The upper half completes the entry in an eight-entry word queue. When transmission is enabled, the block takes the oldest entry and adds a parity bit as the 32nd bit. It then shifts the word out least significant bit first on two line outputs, one that pulses for ones and one that pulses for zeros.

Between consecutive words the block keeps both lines at null for a fixed gap of four bit times. A flag tells the host when no complete word remains queued. Two line rates can be selected: a fast rate with ten clocks per bit and a slow rate with eighty clocks per bit. Rate and parity sense are sampled when each word starts, so a word is never sent with mixed settings.

Top module: `a429_tx`

## Requirements
- R1: The queue holds at most 8 words. A completed write that arrives while 8 words are queued is discarded, and exactly 8 words are then transmitted.
- R2: A word is formed from two writes. A strobe on `load_first` captures `bus_in[15:0]` as payload bits 15..0. A later strobe on `load_second` supplies `bus_in[14:0]` as payload bits 30..16 and enqueues the word. `bus_in[15]` on the second write is ignored.
- R3: A `load_second` strobe with no pending first half since reset or since the previous second half creates no queue entry.
- R4: Bits are sent payload bit 0 first and parity last. In each bit period the first half drives `line_one`=1, `line_zero`=0 for a 1 (or the reverse for a 0), and the second half drives both lines low. Both lines are never high together.
- R5: Bit 32 is parity over the 31 payload bits. When `parity_even`=0 the 32-bit word has an odd number of ones, and when `parity_even`=1 it has an even number. The control is sampled in the cycle the word starts.
- R6: A bit period lasts 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1, with a high half of 5 or 40 clocks. The control is sampled in the cycle the word starts.
- R7: After each word both lines stay low for exactly 4 bit periods. If a word is queued and enable is high at the end of the gap, the next word begins on the following clock with no extra idle cycle.
- R8: No word starts while `tx_en` is low. A word already started completes, including its gap.
- R9: `queue_empty` is 1 exactly when no complete word is queued. It falls on the clock after an enqueue and rises on the clock at which the last word is taken.
- R10: Synchronous reset empties the queue, drops any pending first half, ends any word in progress, and drives both lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 16 | Shared half-word write bus |
| load_first | input | 1 | Strobe capturing the lower half |
| load_second | input | 1 | Strobe supplying the upper half and enqueuing |
| tx_en | input | 1 | Allows queued words to start |
| rate_slow | input | 1 | 1 selects 80 clocks per bit, 0 selects 10 |
| parity_even | input | 1 | 1 selects even word parity, 0 selects odd |
| line_one | output | 1 | High during the first half of a 1 bit |
| line_zero | output | 1 | High during the first half of a 0 bit |
| queue_empty | output | 1 | No complete word is queued |

## Verification
The assertions take as given that each strobe lasts one clock and that `load_first` and `load_second` are never high in the same cycle. They also assume `rst` is high at the first clock edge, so the queue level and state register start from known values. The stimulus writes every word as a lower-half pulse followed by an upper-half pulse on separate clocks. It issues a lone upper half only to exercise the orphan case. It changes rate and parity only between words, while the bench model also samples them at word start.

// File: rtl/a429tx_pkg.sv
package a429tx_pkg;

    localparam int HALF_BITS    = 16;
    localparam int PAYLOAD_BITS = 31;
    localparam int WORD_BITS    = PAYLOAD_BITS + 1;
    localparam int UPPER_BITS   = PAYLOAD_BITS - HALF_BITS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_t;

    typedef struct packed {
        logic [UPPER_BITS-1:0] upper;
        logic [HALF_BITS-1:0]  lower;
    } payload_t;

    // Parity bit that gives the whole word odd (even_sel=0) or even weight.
    function automatic logic word_parity(input payload_t p, input logic even_sel);
        logic ones_odd;
        ones_odd = ^p;
        return even_sel ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/a429tx_loader.sv
module a429tx_loader
    import a429tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HALF_BITS-1:0] bus_in,
    input  logic                 load_first,
    input  logic                 load_second,
    input  logic                 q_full,
    output logic                 wr_en,
    output payload_t             wr_word
);

    logic [HALF_BITS-1:0] lower_hold;
    logic                 lower_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            lower_hold  <= '0;
            lower_valid <= 1'b0;
        end else if (load_first) begin
            lower_hold  <= bus_in;
            lower_valid <= 1'b1;
        end else if (load_second) begin
            lower_valid <= 1'b0;
        end
    end

    always_comb begin
        wr_word.lower = lower_hold;
        wr_word.upper = bus_in[UPPER_BITS-1:0];
        wr_en         = load_second && lower_valid && !q_full;
    end

endmodule

// File: rtl/a429tx_wordq.sv
module a429tx_wordq #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 31,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= next_ptr(wr_ptr);
            if (rd_en) rd_ptr <= next_ptr(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign rd_data = store[rd_ptr];

endmodule

// File: rtl/a429tx_bittimer.sv
module a429tx_bittimer #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    localparam int PW      = $clog2(DIV_SLOW)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic slow_sel,
    input  logic running,
    output logic bit_end,
    output logic high_half
);

    logic [PW-1:0] phase;
    logic          slow_q;
    logic [PW-1:0] last_phase;
    logic [PW-1:0] half_point;

    always_comb begin
        last_phase = slow_q ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
        half_point = slow_q ? PW'(DIV_SLOW / 2) : PW'(DIV_FAST / 2);
        bit_end    = running && (phase == last_phase);
        high_half  = phase < half_point;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            slow_q <= 1'b0;
        end else if (restart) begin
            phase  <= '0;
            slow_q <= slow_sel;
        end else if (!running || bit_end) begin
            phase  <= '0;
        end else begin
            phase  <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/a429tx_serializer.sv
module a429tx_serializer
    import a429tx_pkg::*;
#(
    parameter int GAP_BITS = 4,
    localparam int BW      = $clog2(WORD_BITS),
    localparam int GW      = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_en,
    input  logic      parity_even,
    input  logic      q_empty,
    input  payload_t  head_word,
    input  logic      bit_end,
    input  logic      high_half,
    output logic      pop,
    output logic      running,
    output tx_state_t state,
    output logic      line_one,
    output logic      line_zero
);

    logic [WORD_BITS-1:0] shreg;
    logic [BW-1:0]        bit_idx;
    logic [GW-1:0]        gap_idx;
    logic                 gap_done;

    always_comb begin
        gap_done  = (state == ST_GAP) && bit_end && (gap_idx == GW'(GAP_BITS - 1));
        pop       = tx_en && !q_empty && ((state == ST_IDLE) || gap_done);
        running   = (state != ST_IDLE);
        line_one  = (state == ST_SEND) && high_half && shreg[0];
        line_zero = (state == ST_SEND) && high_half && !shreg[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            gap_idx <= '0;
        end else if (pop) begin
            state   <= ST_SEND;
            shreg   <= {word_parity(head_word, parity_even), head_word};
            bit_idx <= '0;
        end else begin
            case (state)
                ST_SEND: begin
                    if (bit_end) begin
                        if (bit_idx == BW'(WORD_BITS - 1)) begin
                            state   <= ST_GAP;
                            gap_idx <= '0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= shreg >> 1;
                        end
                    end
                end
                ST_GAP: begin
                    if (bit_end) begin
                        if (gap_idx == GW'(GAP_BITS - 1)) state <= ST_IDLE;
                        else gap_idx <= gap_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/a429_tx.sv
module a429_tx
    import a429tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HALF_BITS-1:0] bus_in,
    input  logic                 load_first,
    input  logic                 load_second,
    input  logic                 tx_en,
    input  logic                 rate_slow,
    input  logic                 parity_even,
    output logic                 line_one,
    output logic                 line_zero,
    output logic                 queue_empty
);

    logic      wr_en;
    payload_t  wr_word;
    payload_t  head_word;
    logic      pop;
    logic      running;
    logic      bit_end;
    logic      high_half;
    logic      q_full;
    logic [LW-1:0] q_level;
    tx_state_t tx_state;

    assign q_full      = (q_level == LW'(DEPTH));
    assign queue_empty = (q_level == '0);

    a429tx_loader u_load (
        .clk         (clk),
        .rst         (rst),
        .bus_in      (bus_in),
        .load_first  (load_first),
        .load_second (load_second),
        .q_full      (q_full),
        .wr_en       (wr_en),
        .wr_word     (wr_word)
    );

    a429tx_wordq #(.DEPTH(DEPTH), .WIDTH(PAYLOAD_BITS)) u_q (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_word),
        .rd_en   (pop),
        .rd_data (head_word),
        .level   (q_level)
    );

    a429tx_bittimer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tim (
        .clk       (clk),
        .rst       (rst),
        .restart   (pop),
        .slow_sel  (rate_slow),
        .running   (running),
        .bit_end   (bit_end),
        .high_half (high_half)
    );

    a429tx_serializer #(.GAP_BITS(GAP_BITS)) u_ser (
        .clk         (clk),
        .rst         (rst),
        .tx_en       (tx_en),
        .parity_even (parity_even),
        .q_empty     (queue_empty),
        .head_word   (head_word),
        .bit_end     (bit_end),
        .high_half   (high_half),
        .pop         (pop),
        .running     (running),
        .state       (tx_state),
        .line_one    (line_one),
        .line_zero   (line_zero)
    );

endmodule

// File: rtl/a429tx_checker.sv
module a429tx_checker
    import a429tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_en,
    input logic          line_one,
    input logic          line_zero,
    input logic          queue_empty,
    input logic          pop,
    input logic [LW-1:0] level,
    input tx_state_t     state
);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(DEPTH) && !pop) |=> (level == LW'(DEPTH)));

    assert_lines_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(line_one && line_zero));

    assert_gap_null_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> (!line_one && !line_zero));

    assert_idle_null_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!line_one && !line_zero));

    assert_hold_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && state == ST_IDLE) |=> (state == ST_IDLE));

    assert_pop_has_word_R9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !queue_empty);

    assert_empty_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(queue_empty) |-> $past(pop));

endmodule

bind a429_tx a429tx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .line_one    (line_one),
    .line_zero   (line_zero),
    .queue_empty (queue_empty),
    .pop         (pop),
    .level       (q_level),
    .state       (tx_state)
);

// File: tb/sim_a429_tx.sv
module sim_a429_tx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_in = '0;
    logic        load_first = 1'b0;
    logic        load_second = 1'b0;
    logic        tx_en = 1'b0;
    logic        rate_slow = 1'b0;
    logic        parity_even = 1'b0;
    logic        line_one;
    logic        line_zero;
    logic        queue_empty;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    pulses = 0;
    bit    prev_active = 1'b0;
    bit    armed = 1'b0;
    string cur_tag = "R10";

    // Reference model state.
    int          ms = 0;        // 0 idle, 1 send, 2 gap
    int          mph = 0;
    int          mbit = 0;
    int          mgap = 0;
    int          mlim = 10;
    logic [31:0] mword = '0;
    logic [30:0] mq[$];
    logic [15:0] mlo = '0;
    bit          mlv = 1'b0;

    a429_tx u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_in      (bus_in),
        .load_first  (load_first),
        .load_second (load_second),
        .tx_en       (tx_en),
        .rate_slow   (rate_slow),
        .parity_even (parity_even),
        .line_one    (line_one),
        .line_zero   (line_zero),
        .queue_empty (queue_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        int  sz0;
        bit  start;
        bit  pty;
        cycles++;
        if (rst) begin
            ms = 0; mph = 0; mbit = 0; mgap = 0; mlim = 10;
            mq.delete(); mlv = 1'b0; mlo = '0;
            armed = 1'b1;
        end else begin
            sz0 = mq.size();
            start = tx_en && sz0 > 0 &&
                    (ms == 0 || (ms == 2 && mph == mlim - 1 && mgap == 3));
            if (start) begin
                mword[30:0] = mq.pop_front();
                // R5: odd total weight by default, even when selected
                pty = ^mword[30:0];
                mword[31] = parity_even ? pty : ~pty;
                mlim = rate_slow ? 80 : 10;   // R6
                ms = 1; mph = 0; mbit = 0;
            end else if (ms == 1) begin
                if (mph == mlim - 1) begin
                    mph = 0;
                    if (mbit == 31) begin ms = 2; mgap = 0; end
                    else mbit++;
                end else mph++;
            end else if (ms == 2) begin
                if (mph == mlim - 1) begin
                    mph = 0;
                    if (mgap == 3) ms = 0; else mgap++;
                end else mph++;
            end
            if (load_second && mlv && sz0 < 8) mq.push_back({bus_in[14:0], mlo});
            if (load_first) begin mlo = bus_in; mlv = 1'b1; end
            else if (load_second) mlv = 1'b0;
        end
    end

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        bit e1, e0, ee;
        if (armed) begin
            e1 = (ms == 1 && mph < mlim / 2) ?  mword[mbit] : 1'b0;
            e0 = (ms == 1 && mph < mlim / 2) ? ~mword[mbit] : 1'b0;
            ee = (mq.size() == 0);
            check(line_one === e1, cur_tag, "line_one", int'(line_one), int'(e1));
            check(line_zero === e0, cur_tag, "line_zero", int'(line_zero), int'(e0));
            check(queue_empty === ee, "R9", "queue_empty", int'(queue_empty), int'(ee));
            if ((line_one || line_zero) && !prev_active) pulses++;
            prev_active = line_one || line_zero;
        end
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", "timeout", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic write_word(input logic [30:0] w);
        @(negedge clk);
        bus_in = w[15:0]; load_first = 1'b1;
        @(negedge clk);
        load_first = 1'b0;
        bus_in = {1'b1, w[30:16]};   // R2: top bus bit must be ignored
        load_second = 1'b1;
        @(negedge clk);
        load_second = 1'b0;
        bus_in = '0;
    endtask

    task automatic drain();
        while (!(ms == 0 && mq.size() == 0)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state after reset
        check(line_one === 1'b0, "R10", "line_one after reset", int'(line_one), 0);
        check(line_zero === 1'b0, "R10", "line_zero after reset", int'(line_zero), 0);
        check(queue_empty === 1'b1, "R10", "empty after reset", int'(queue_empty), 1);
        rst = 1'b0;
        @(negedge clk);

        // R3: lone upper half
        cur_tag = "R3";
        bus_in = 16'h1234; load_second = 1'b1;
        @(negedge clk);
        load_second = 1'b0;
        repeat (2) @(negedge clk);
        check(queue_empty === 1'b1, "R3", "orphan upper half", int'(queue_empty), 1);

        // R2 + R4: one word at fast rate, odd parity
        cur_tag = "R4";
        write_word(31'h2AB5_1C3E);
        check(queue_empty === 1'b0, "R2", "word enqueued", int'(queue_empty), 0);
        pulses = 0;
        tx_en = 1'b1;
        drain();
        check(pulses == 32, "R4", "pulses per word", pulses, 32);

        // R5: even parity over several patterns, back to back (R7)
        cur_tag = "R5";
        parity_even = 1'b1;
        tx_en = 1'b0;
        write_word(31'h0000_0000);
        write_word(31'h7FFF_FFFF);
        write_word(31'h5555_5555);
        cur_tag = "R7";
        tx_en = 1'b1;
        drain();
        parity_even = 1'b0;

        // R6: slow rate
        cur_tag = "R6";
        rate_slow = 1'b1;
        write_word(31'h1357_9BDF);
        drain();
        rate_slow = 1'b0;

        // R1: nine writes while disabled, eight sent
        cur_tag = "R1";
        tx_en = 1'b0;
        for (int i = 0; i < 9; i++) write_word(31'(32'h0101_0101 * (i + 1)));
        check(queue_empty === 1'b0, "R1", "queue filled", int'(queue_empty), 0);
        pulses = 0;
        tx_en = 1'b1;
        drain();
        check(pulses == 8 * 32, "R1", "pulses for full queue", pulses, 256);

        // R8: disable during a word
        cur_tag = "R8";
        tx_en = 1'b0;
        write_word(31'h0F0F_0F0F);
        write_word(31'h70F0_F0F0);
        tx_en = 1'b1;
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        pulses = 0;
        repeat (800) @(negedge clk);
        check(queue_empty === 1'b0, "R8", "second word held", int'(queue_empty), 0);
        check(!line_one && !line_zero, "R8", "lines null when held",
              int'(line_one | line_zero), 0);
        tx_en = 1'b1;
        drain();
        check(pulses >= 32, "R8", "held word sent after enable", pulses, 32);

        // R10: reset in mid-word, then a lone upper half
        cur_tag = "R10";
        tx_en = 1'b0;
        write_word(31'h4444_4444);
        @(negedge clk);
        bus_in = 16'hBEEF; load_first = 1'b1;
        @(negedge clk);
        load_first = 1'b0;
        tx_en = 1'b1;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(queue_empty === 1'b1, "R10", "empty after mid reset", int'(queue_empty), 1);
        check(!line_one && !line_zero, "R10", "lines null after reset",
              int'(line_one | line_zero), 0);
        load_second = 1'b1; bus_in = 16'h0001;
        @(negedge clk);
        load_second = 1'b0;
        repeat (2) @(negedge clk);
        check(queue_empty === 1'b1, "R10", "pending half dropped", int'(queue_empty), 1);
        repeat (20) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule